// File: doc/BRIEF.md
# Status Flag Register and Branch Condition Evaluator

This block keeps the four processor status bits (negative, zero, overflow, carry) and turns a 4-bit condition selector into a branch-taken decision. A processor's execute stage feeds it the ALU result with its carry-out and overflow. It also feeds the carry shifted out by a shift instruction and a two-bit write mode. The write mode says which flags, if any, the current instruction may change. Instructions that do not set flags leave the register untouched, so a later branch still sees the flags of the last instruction that set them.

The decision output is purely combinational from the stored flags and the selector. A branch in the same cycle as a flag-setting instruction therefore still sees the older flags. The sixteen conditions form eight complementary pairs: bit 0 of the selector inverts the test chosen by bits 3:1. This covers the single-flag tests as well as signed and unsigned magnitude comparisons.

Top module: `cc_branch_eval`

## Requirements
- R1: While `rst` is high at a rising edge, the stored flags become 0000 after that edge. `flags` is ordered {N, Z, V, C}, with N at bit 3 and C at bit 0.
- R2: With `wr_mode` = 00 (hold), an edge leaves all four flags unchanged.
- R3: With `wr_mode` = 01 (full update), the next edge loads N = MSB of `alu_result`, Z = (`alu_result` == 0), V = `alu_ovf` and C = `alu_carry`.
- R4: With `wr_mode` = 10 (shift), the next edge loads C = `shift_carry`. N, Z and V stay unchanged.
- R5: With `wr_mode` = 11 (test), the next edge loads N and Z from `alu_result` as in R3. V and C stay unchanged.
- R6: Selector 0 always gives `taken` = 1, and selector 1 always gives `taken` = 0.
- R7: Selectors 2/3 test Z and ~Z, 4/5 test C and ~C, 6/7 test N and ~N, and 8/9 test V and ~V.
- R8: Selector 10 (unsigned lower-or-same) is C | Z, and selector 11 (unsigned higher) is ~(C | Z).
- R9: Selector 12 (signed less) is N ^ V, 13 is its complement, 14 (signed less-or-equal) is Z | (N ^ V), and 15 is its complement.
- R10: For any stored flags, the selectors 2k and 2k+1 always give opposite `taken` values.
- R11: `taken` depends only on the stored flags and `cond`. A flag write pending in the current cycle does not affect it until after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 2 | Flag write mode: 00 hold, 01 full, 10 shift carry, 11 N/Z only |
| alu_result | input | DATA_W | ALU result used for N and Z |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| shift_carry | input | 1 | Bit shifted out by a shift instruction |
| cond | input | 4 | Branch condition selector |
| flags | output | 4 | Stored flags {N, Z, V, C} |
| taken | output | 1 | Branch taken for the selected condition |

## Verification
On every cycle, the assertions check how each write mode changes or preserves the stored flags, and that reset clears them. They also check the fixed always/never selectors and the zero-flag test against the stored flags. The full sixteen-way decode, including the signed and unsigned comparisons and the complementary pairing, is shown only by the bench. The bench sweeps every selector over every reachable flag state. Only the bench's scenarios show that a flag write pending in the same cycle does not affect the branch decision.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        FW_HOLD  = 2'b00,
        FW_ALL   = 2'b01,
        FW_CARRY = 2'b10,
        FW_NZ    = 2'b11
    } flag_wr_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Bits 3:1 pick the test; bit 0 inverts it.
    typedef enum logic [2:0] {
        GRP_TRUE  = 3'd0,
        GRP_ZERO  = 3'd1,
        GRP_CARRY = 3'd2,
        GRP_NEG   = 3'd3,
        GRP_OVF   = 3'd4,
        GRP_ULE   = 3'd5,
        GRP_SLT   = 3'd6,
        GRP_SLE   = 3'd7
    } cond_grp_e;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic logic grp_test(input cond_grp_e g, input flags_t f);
        logic r;
        unique case (g)
            GRP_TRUE:  r = 1'b1;
            GRP_ZERO:  r = f.z;
            GRP_CARRY: r = f.c;
            GRP_NEG:   r = f.n;
            GRP_OVF:   r = f.v;
            GRP_ULE:   r = f.c | f.z;
            GRP_SLT:   r = f.n ^ f.v;
            GRP_SLE:   r = f.z | (f.n ^ f.v);
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cc_flag_next.sv
module cc_flag_next
    import cc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  flag_wr_e            mode,
    input  logic [DATA_W-1:0]   result,
    input  logic                carry,
    input  logic                ovf,
    input  logic                sh_carry,
    input  flags_t              cur,
    output flags_t              nxt,
    output logic                wr_en
);
    localparam int MSB = DATA_W - 1;

    logic res_neg;
    logic res_zero;

    assign res_neg  = result[MSB];
    assign res_zero = (result == '0);

    always_comb begin
        nxt   = cur;
        wr_en = 1'b1;
        unique case (mode)
            FW_HOLD: wr_en = 1'b0;
            FW_ALL: begin
                nxt.n = res_neg;
                nxt.z = res_zero;
                nxt.v = ovf;
                nxt.c = carry;
            end
            FW_CARRY: nxt.c = sh_carry;
            FW_NZ: begin
                nxt.n = res_neg;
                nxt.z = res_zero;
            end
            default: wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= FLAGS_RESET;
        else if (wr_en)
            q <= d;
    end
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
    import cc_pkg::*;
#(
    parameter int COND_W = 4
) (
    input  logic [COND_W-1:0] sel,
    input  flags_t            f,
    output logic              hit
);
    localparam int GRP_W = COND_W - 1;

    cond_grp_e grp;
    logic      base;

    assign grp  = cond_grp_e'(sel[COND_W-1 -: GRP_W]);
    assign base = grp_test(grp, f);
    assign hit  = base ^ sel[0];
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
    import cc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_mode,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic              shift_carry,
    input  logic [3:0]        cond,
    output logic [3:0]        flags,
    output logic              taken
);
    localparam int COND_W = 4;

    flags_t flg_q;
    flags_t flg_d;
    logic   flg_we;

    cc_flag_next #(.DATA_W(DATA_W)) u_next (
        .mode     (flag_wr_e'(wr_mode)),
        .result   (alu_result),
        .carry    (alu_carry),
        .ovf      (alu_ovf),
        .sh_carry (shift_carry),
        .cur      (flg_q),
        .nxt      (flg_d),
        .wr_en    (flg_we)
    );

    cc_flag_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (flg_we),
        .d     (flg_d),
        .q     (flg_q)
    );

    cc_cond_eval #(.COND_W(COND_W)) u_eval (
        .sel (cond),
        .f   (flg_q),
        .hit (taken)
    );

    assign flags = flg_q;
endmodule

// File: rtl/cc_branch_eval_chk.sv
module cc_branch_eval_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        wr_mode,
    input logic [DATA_W-1:0] alu_result,
    input logic              alu_carry,
    input logic              alu_ovf,
    input logic              shift_carry,
    input logic [3:0]        cond,
    input logic [3:0]        flags,
    input logic              taken
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> flags == 4'b0000);

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
        wr_mode == 2'b00 |=> $stable(flags));

    assert_full_load_R3: assert property (@(posedge clk) disable iff (rst)
        wr_mode == 2'b01 |=>
            flags == {$past(alu_result[DATA_W-1]), $past(alu_result == '0),
                      $past(alu_ovf), $past(alu_carry)});

    assert_shift_carry_R4: assert property (@(posedge clk) disable iff (rst)
        wr_mode == 2'b10 |=>
            (flags[3:1] == $past(flags[3:1])) && (flags[0] == $past(shift_carry)));

    assert_nz_only_R5: assert property (@(posedge clk) disable iff (rst)
        wr_mode == 2'b11 |=>
            (flags[1:0] == $past(flags[1:0])) &&
            (flags[3] == $past(alu_result[DATA_W-1])) &&
            (flags[2] == $past(alu_result == '0)));

    assert_always_never_R6: assert property (@(posedge clk) disable iff (rst)
        (cond[3:1] == 3'd0) |-> (taken == !cond[0]));

    assert_zero_test_R7: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd2) |-> (taken == flags[2]));
endmodule

bind cc_branch_eval cc_branch_eval_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_mode     (wr_mode),
    .alu_result  (alu_result),
    .alu_carry   (alu_carry),
    .alu_ovf     (alu_ovf),
    .shift_carry (shift_carry),
    .cond        (cond),
    .flags       (flags),
    .taken       (taken)
);

// File: tb/cc_branch_eval_bench.sv
`timescale 1ns/1ps
module cc_branch_eval_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   wr_mode;
    logic [W-1:0] alu_result;
    logic         alu_carry;
    logic         alu_ovf;
    logic         shift_carry;
    logic [3:0]   cond;
    logic [3:0]   flags;
    logic         taken;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cc_branch_eval #(.DATA_W(W)) u_cc_branch_eval (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .alu_result(alu_result),
        .alu_carry(alu_carry), .alu_ovf(alu_ovf), .shift_carry(shift_carry),
        .cond(cond), .flags(flags), .taken(taken)
    );

    // model flags {N,Z,V,C}
    logic mn, mz, mv, mc;

    function automatic logic ref_taken(input logic [3:0] c, input logic n, z, v, cy);
        case (c)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return z;
            4'd3:  return !z;
            4'd4:  return cy;
            4'd5:  return !cy;
            4'd6:  return n;
            4'd7:  return !n;
            4'd8:  return v;
            4'd9:  return !v;
            4'd10: return cy || z;
            4'd11: return !(cy || z);
            4'd12: return n != v;
            4'd13: return n == v;
            4'd14: return z || (n != v);
            default: return !(z || (n != v));
        endcase
    endfunction

    function automatic string cond_req(input logic [3:0] c);
        if (c < 4'd2)  return "R6";
        if (c < 4'd10) return "R7";
        if (c < 4'd12) return "R8";
        return "R9";
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] m, input logic [W-1:0] r,
                        input logic o, input logic cy, input logic s);
        @(negedge clk);
        wr_mode = m; alu_result = r; alu_ovf = o; alu_carry = cy; shift_carry = s;
        @(posedge clk);
        #1;
        wr_mode = 2'b00;
    endtask

    task automatic chk_flags(input string req);
        chk(req, {4'b0, flags}, {4'b0, mn, mz, mv, mc});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rv [3];
        logic t_even;
        rv[0] = 8'h00; rv[1] = 8'h80; rv[2] = 8'h01;
        rst = 1'b1; wr_mode = 2'b01; alu_result = 8'h80;
        alu_carry = 1'b1; alu_ovf = 1'b1; shift_carry = 1'b1; cond = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        mn = 0; mz = 0; mv = 0; mc = 0;
        chk_flags("R1");
        @(negedge clk);
        rst = 1'b0; wr_mode = 2'b00;

        // R3/R6..R10: sweep all reachable flag states and all selectors
        for (int ri = 0; ri < 3; ri++) begin
            for (int vc = 0; vc < 4; vc++) begin
                load(2'b01, rv[ri], vc[1], vc[0], !vc[0]);
                mn = rv[ri][W-1]; mz = (rv[ri] == 0); mv = vc[1]; mc = vc[0];
                chk_flags("R3");
                t_even = 1'b0;
                for (int c = 0; c < 16; c++) begin
                    cond = 4'(c);
                    #0.5;
                    chk(cond_req(4'(c)), {7'b0, taken}, {7'b0, ref_taken(4'(c), mn, mz, mv, mc)});
                    if (c[0]) chk("R10", {7'b0, taken}, {7'b0, !t_even});
                    else t_even = taken;
                end
            end
        end

        // R2: hold over several edges with busy inputs
        @(negedge clk);
        alu_result = 8'h00; alu_ovf = !mv; alu_carry = !mc; shift_carry = !mc;
        repeat (4) @(posedge clk);
        #1;
        chk_flags("R2");

        // R4: shift updates carry only
        load(2'b01, 8'hF0, 1'b1, 1'b0, 1'b0);
        mn = 1; mz = 0; mv = 1; mc = 0;
        load(2'b10, 8'h00, 1'b0, 1'b0, 1'b1);
        mc = 1;
        chk_flags("R4");
        load(2'b10, 8'h00, 1'b0, 1'b1, 1'b0);
        mc = 0;
        chk_flags("R4");

        // R5: test mode updates N and Z only
        load(2'b01, 8'h05, 1'b1, 1'b1, 1'b0);
        mn = 0; mz = 0; mv = 1; mc = 1;
        load(2'b11, 8'h00, 1'b0, 1'b0, 1'b0);
        mn = 0; mz = 1;
        chk_flags("R5");
        load(2'b11, 8'h9C, 1'b0, 1'b0, 1'b0);
        mn = 1; mz = 0;
        chk_flags("R5");

        // R11: pending write does not change taken before the edge
        load(2'b01, 8'h33, 1'b0, 1'b0, 1'b0);
        mn = 0; mz = 0; mv = 0; mc = 0;
        @(negedge clk);
        cond = 4'd2;
        wr_mode = 2'b01; alu_result = 8'h00;
        #1;
        chk("R11", {7'b0, taken}, 8'd0);
        @(posedge clk);
        #1;
        wr_mode = 2'b00;
        chk("R11", {7'b0, taken}, 8'd1);

        // R1: reset mid-run clears flags
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        mn = 0; mz = 0; mv = 0; mc = 0;
        chk_flags("R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule